// File: doc/BRIEF.md
# Hot-Swap Power Sequencing Controller

This block is the digital sequencer of a hot-swap power switch. Its inputs are comparator flags: supply lockout good, the window input against its undervoltage and overvoltage thresholds (each with a high and a low trip point for hysteresis), the sense voltage against the circuit-breaker and current-limit levels, and a gate-low status. Every flag passes through a two-flop synchronizer before the state machine uses it. The block drives a gate-enable output, a timer-mode code and status outputs.

An up/down saturating counter takes the place of a timer capacitor. After the supply and window input become valid, the controller runs an initial timing cycle. In this cycle the counter climbs slowly to a high threshold and is then pulled quickly back to a low threshold. A start-up follows, in which the gate is enabled. After that the controller stays in normal operation.

In normal operation the counter integrates faults asymmetrically. It climbs fast while sense is above the circuit-breaker level and falls slowly otherwise, so repeated short overcurrent events add up to a latch-off. An overvoltage during power-up discharges the counter and restarts the initial cycle. An overvoltage during normal operation only removes the gate until it clears, and leaves the counter alone. A latched fault is cleared only by an undervoltage lockout or by reset.

Top module: `hsw_seq_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, state_o is 0 (lockout), gate_en_o is 0, timer_o is 0, fault_latched_o is 0 and cl_active_o is 0.
- R2: In the initial timing state (state_o = 2), timer_o increases by TMR_SLOW every cycle. Once timer_o is at or above TMR_HI, the next state is the quick-clear state (state_o = 3).
- R3: In the quick-clear state, timer_o falls by TMR_QUICK per cycle, stopping at 0. Once it is at or below TMR_LO, the next state is the arm state (state_o = 4). The arm state moves to the run state (state_o = 5) only while gate_low is set and the circuit-breaker flag is clear. gate_en_o is 1 only in the run state.
- R4: The wait state (state_o = 1) moves to the initial timing state only when all of these hold: the window is above undervoltage-high, the window is not above overvoltage-high, timer_o is below TMR_LO, gate_low is set, and the circuit-breaker flag is clear.
- R5: In the run state, timer_o rises by TMR_FAST per cycle while the circuit-breaker flag is set. Otherwise it falls by TMR_SLOW per cycle, stopping at 0.
- R6: When timer_o is at or above TMR_HI in the run state, the next state is the latched-off state (state_o = 7). In that state gate_en_o is 0 and fault_latched_o is 1. Short fault pulses that are each too short to trip on their own add up until this happens.
- R7: The latched-off state ignores the circuit-breaker and overvoltage flags. Its timer_o keeps rising slowly and saturates at all ones. It is left only through lockout.
- R8: A low supply-good flag or a low undervoltage-low flag forces the lockout state (state_o = 0) from any state. Lockout clears timer_o to 0 and gate_en_o to 0. Lockout is left, to the wait state, only once the undervoltage-high flag is also set; a full initial timing cycle then follows.
- R9: An overvoltage-high flag in the initial timing or arm state moves to the power-up overvoltage state (state_o = 8). There timer_o falls by TMR_QUICK per cycle and gate_en_o is 0. The controller returns to the wait state only when the overvoltage-low flag clears.
- R10: An overvoltage-high flag in the run state moves to the overvoltage-off state (state_o = 6). There timer_o holds its value and gate_en_o is 0. The controller returns to the run state when the overvoltage-low flag clears.
- R11: A change on any comparator input takes effect on state_o and gate_en_o at the third rising clock edge after it is applied.
- R12: cl_active_o equals the synchronized current-limit flag while in the run state, and is 0 in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| supply_ok_i | input | 1 | Supply above lockout level |
| win_uvlo_ok_i | input | 1 | Window input above undervoltage-low trip |
| win_uvhi_ok_i | input | 1 | Window input above undervoltage-high trip |
| win_ovhi_i | input | 1 | Window input above overvoltage-high trip |
| win_ovlo_i | input | 1 | Window input above overvoltage-low trip |
| sns_cb_i | input | 1 | Sense above circuit-breaker level |
| sns_cl_i | input | 1 | Sense above current-limit level |
| gate_low_i | input | 1 | Gate voltage below its low level |
| gate_en_o | output | 1 | Enable for the pass-transistor gate drive |
| tmr_mode_o | output | 3 | Timer action: 0 hold, 1 clear, 2 slow up, 3 fast up, 4 slow down, 5 quick down |
| state_o | output | 4 | Sequencer state code (see requirements) |
| fault_latched_o | output | 1 | Latched-off fault status |
| cl_active_o | output | 1 | Current limit seen while running |
| timer_o | output | TMR_W | Fault timer value |

## Verification
The bench builds the block with TMR_HI = 400, TMR_LO = 20, TMR_SLOW = 4, TMR_FAST = 160 (forty times the slow step) and TMR_QUICK = 64. With these values the initial timing cycle lasts about a hundred cycles. A two-cycle overcurrent reaches 320 and stays below the trip level. Three single-cycle pulses ten cycles apart climb 160, 284, 408 and cross 400, so the accumulation case is reached with exact numbers. The quick step takes the counter from the high threshold to below the low threshold in a handful of cycles, which leaves the arm-state gating and the overvoltage paths easy to observe.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

  typedef enum logic [3:0] {
    ST_LOCK    = 4'd0,
    ST_WAIT    = 4'd1,
    ST_INIT    = 4'd2,
    ST_CLEAR   = 4'd3,
    ST_ARM     = 4'd4,
    ST_RUN     = 4'd5,
    ST_OVOFF   = 4'd6,
    ST_LATCH   = 4'd7,
    ST_INIT_OV = 4'd8
  } hsw_state_e;

  typedef enum logic [2:0] {
    TM_HOLD     = 3'd0,
    TM_CLR      = 3'd1,
    TM_SLOW_UP  = 3'd2,
    TM_FAST_UP  = 3'd3,
    TM_SLOW_DN  = 3'd4,
    TM_QUICK_DN = 3'd5
  } tmr_mode_e;

  localparam int unsigned NUM_FLAGS = 8;

  typedef struct packed {
    logic supply_ok;
    logic uvlo_ok;
    logic uvhi_ok;
    logic ovhi;
    logic ovlo;
    logic cb;
    logic cl;
    logic gate_low;
  } cmp_flags_t;

endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= 2'b00;
      end else begin
        stage_q <= {stage_q[0], async_i[i]};
      end
    end

    assign sync_o[i] = stage_q[1];
  end

endmodule

// File: rtl/hsw_fault_timer.sv
module hsw_fault_timer
  import hsw_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned SLOW  = 6,
  parameter int unsigned FAST  = 230,
  parameter int unsigned QUICK = 1024
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tmr_mode_e    mode_i,
  output logic [W-1:0] value_o
);

  localparam logic [W:0] SLOW_S  = (W+1)'(SLOW);
  localparam logic [W:0] FAST_S  = (W+1)'(FAST);
  localparam logic [W:0] QUICK_S = (W+1)'(QUICK);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W:0]   up_step;
  logic [W:0]   dn_step;
  logic [W:0]   up_sum;
  logic         cnt_en;

  always_comb begin
    up_step = '0;
    dn_step = '0;
    unique case (mode_i)
      TM_SLOW_UP:  up_step = SLOW_S;
      TM_FAST_UP:  up_step = FAST_S;
      TM_SLOW_DN:  dn_step = SLOW_S;
      TM_QUICK_DN: dn_step = QUICK_S;
      default: ;
    endcase
  end

  assign up_sum = {1'b0, cnt_q} + up_step;

  always_comb begin
    if (mode_i == TM_CLR) begin
      cnt_d = '0;
    end else if (up_step != '0) begin
      cnt_d = up_sum[W] ? '1 : up_sum[W-1:0];
    end else if ({1'b0, cnt_q} < dn_step) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q - dn_step[W-1:0];
    end
  end

  assign cnt_en = (mode_i != TM_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign value_o = cnt_q;

endmodule

// File: rtl/hsw_seq_fsm.sv
module hsw_seq_fsm
  import hsw_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned TMR_HI = 16'hF000,
  parameter int unsigned TMR_LO = 16'h0400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         supply_ok_i,
  input  logic         uvlo_ok_i,
  input  logic         uvhi_ok_i,
  input  logic         ovhi_i,
  input  logic         ovlo_i,
  input  logic         cb_i,
  input  logic         gate_low_i,
  input  logic [W-1:0] timer_i,
  output hsw_state_e   state_o,
  output tmr_mode_e    mode_o
);

  localparam logic [W-1:0] HI_V = W'(TMR_HI);
  localparam logic [W-1:0] LO_V = W'(TMR_LO);

  hsw_state_e state_q;
  hsw_state_e state_d;
  logic       lockout;
  logic       at_hi;
  logic       at_lo;
  logic       below_lo;
  logic       start_ok;

  assign lockout  = !supply_ok_i || !uvlo_ok_i;
  assign at_hi    = (timer_i >= HI_V);
  assign at_lo    = (timer_i <= LO_V);
  assign below_lo = (timer_i <  LO_V);
  assign start_ok = gate_low_i && !cb_i;

  always_comb begin
    state_d = state_q;
    if (lockout) begin
      state_d = ST_LOCK;
    end else begin
      unique case (state_q)
        ST_LOCK:    if (uvhi_ok_i) state_d = ST_WAIT;
        ST_WAIT:    if (uvhi_ok_i && !ovhi_i && below_lo && start_ok) state_d = ST_INIT;
        ST_INIT: begin
          if (ovhi_i)     state_d = ST_INIT_OV;
          else if (at_hi) state_d = ST_CLEAR;
        end
        ST_CLEAR:   if (at_lo) state_d = ST_ARM;
        ST_ARM: begin
          if (ovhi_i)        state_d = ST_INIT_OV;
          else if (start_ok) state_d = ST_RUN;
        end
        ST_RUN: begin
          if (at_hi)       state_d = ST_LATCH;
          else if (ovhi_i) state_d = ST_OVOFF;
        end
        ST_OVOFF:   if (!ovlo_i) state_d = ST_RUN;
        ST_LATCH:   state_d = ST_LATCH;
        ST_INIT_OV: if (!ovlo_i) state_d = ST_WAIT;
        default:    state_d = ST_LOCK;
      endcase
    end
  end

  always_comb begin
    mode_o = TM_HOLD;
    if (lockout) begin
      mode_o = TM_CLR;
    end else begin
      unique case (state_q)
        ST_LOCK:    mode_o = TM_CLR;
        ST_WAIT:    mode_o = TM_SLOW_DN;
        ST_INIT:    mode_o = TM_SLOW_UP;
        ST_CLEAR:   mode_o = TM_QUICK_DN;
        ST_ARM:     mode_o = TM_SLOW_DN;
        ST_RUN:     mode_o = cb_i ? TM_FAST_UP : TM_SLOW_DN;
        ST_OVOFF:   mode_o = TM_HOLD;
        ST_LATCH:   mode_o = TM_SLOW_UP;
        ST_INIT_OV: mode_o = TM_QUICK_DN;
        default:    mode_o = TM_CLR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOCK;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/hsw_seq_ctrl.sv
module hsw_seq_ctrl
  import hsw_pkg::*;
#(
  parameter int unsigned TMR_W     = 16,
  parameter int unsigned TMR_HI    = 16'hF000,
  parameter int unsigned TMR_LO    = 16'h0400,
  parameter int unsigned TMR_SLOW  = 6,
  parameter int unsigned TMR_FAST  = 230,
  parameter int unsigned TMR_QUICK = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok_i,
  input  logic             win_uvlo_ok_i,
  input  logic             win_uvhi_ok_i,
  input  logic             win_ovhi_i,
  input  logic             win_ovlo_i,
  input  logic             sns_cb_i,
  input  logic             sns_cl_i,
  input  logic             gate_low_i,
  output logic             gate_en_o,
  output logic [2:0]       tmr_mode_o,
  output logic [3:0]       state_o,
  output logic             fault_latched_o,
  output logic             cl_active_o,
  output logic [TMR_W-1:0] timer_o
);

  cmp_flags_t       raw_flags;
  cmp_flags_t       flags;
  logic [NUM_FLAGS-1:0] flags_vec;
  hsw_state_e       state;
  tmr_mode_e        mode;
  logic [TMR_W-1:0] timer_val;

  assign raw_flags = '{
    supply_ok: supply_ok_i,
    uvlo_ok:   win_uvlo_ok_i,
    uvhi_ok:   win_uvhi_ok_i,
    ovhi:      win_ovhi_i,
    ovlo:      win_ovlo_i,
    cb:        sns_cb_i,
    cl:        sns_cl_i,
    gate_low:  gate_low_i
  };

  hsw_sync #(
    .W (NUM_FLAGS)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_flags),
    .sync_o  (flags_vec)
  );

  assign flags = cmp_flags_t'(flags_vec);

  hsw_seq_fsm #(
    .W      (TMR_W),
    .TMR_HI (TMR_HI),
    .TMR_LO (TMR_LO)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok_i (flags.supply_ok),
    .uvlo_ok_i   (flags.uvlo_ok),
    .uvhi_ok_i   (flags.uvhi_ok),
    .ovhi_i      (flags.ovhi),
    .ovlo_i      (flags.ovlo),
    .cb_i        (flags.cb),
    .gate_low_i  (flags.gate_low),
    .timer_i     (timer_val),
    .state_o     (state),
    .mode_o      (mode)
  );

  hsw_fault_timer #(
    .W     (TMR_W),
    .SLOW  (TMR_SLOW),
    .FAST  (TMR_FAST),
    .QUICK (TMR_QUICK)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode),
    .value_o (timer_val)
  );

  assign gate_en_o       = (state == ST_RUN);
  assign fault_latched_o = (state == ST_LATCH);
  assign cl_active_o     = flags.cl && (state == ST_RUN);
  assign tmr_mode_o      = mode;
  assign state_o         = state;
  assign timer_o         = timer_val;

endmodule

// File: rtl/hsw_seq_ctrl_chk.sv
module hsw_seq_ctrl_chk
  import hsw_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned TMR_HI = 16'hF000,
  parameter int unsigned SLOW   = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   state_o,
  input logic [W-1:0] timer_o,
  input logic         gate_en_o,
  input logic         fault_latched_o
);

  localparam logic [W-1:0] HI_V   = W'(TMR_HI);
  localparam logic [W-1:0] SLOW_V = W'(SLOW);

  // R2: steady climb during the initial timing cycle
  p_init_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == ST_INIT && state_o == ST_INIT) |-> timer_o == $past(timer_o) + SLOW_V);

  // R3: the quick clear only moves down
  p_clear_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == ST_CLEAR && state_o == ST_CLEAR) |-> timer_o < $past(timer_o));

  // R6: trip threshold reached while running leads to latch-off (or lockout)
  p_trip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_RUN && timer_o >= HI_V) |=> (state_o == ST_LATCH || state_o == ST_LOCK));

  // R7: latch-off is left only for lockout
  p_latch_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == ST_LATCH && state_o != ST_LATCH) |-> state_o == ST_LOCK);

  // R7: latched timer never falls
  p_latch_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == ST_LATCH && state_o == ST_LATCH) |-> timer_o >= $past(timer_o));

  // R8: timer stays at zero through lockout with the gate off
  p_lock_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == ST_LOCK && state_o == ST_LOCK) |-> (timer_o == '0 && !gate_en_o && !fault_latched_o));

  // R10: overvoltage during normal operation freezes the timer
  p_ov_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == ST_OVOFF && state_o != ST_LOCK) |-> $stable(timer_o));

endmodule

bind hsw_seq_ctrl hsw_seq_ctrl_chk #(
  .W      (TMR_W),
  .TMR_HI (TMR_HI),
  .SLOW   (TMR_SLOW)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .state_o         (state_o),
  .timer_o         (timer_o),
  .gate_en_o       (gate_en_o),
  .fault_latched_o (fault_latched_o)
);

// File: tb/hsw_seq_ctrl_bench.sv
module hsw_seq_ctrl_bench;

  localparam int W     = 16;
  localparam int HI    = 400;
  localparam int LO    = 20;
  localparam int SLOW  = 4;
  localparam int FAST  = 160;
  localparam int QUICK = 64;

  localparam logic [3:0] S_LOCK = 4'd0, S_WAIT = 4'd1, S_INIT = 4'd2, S_CLEAR = 4'd3,
                         S_ARM = 4'd4, S_RUN = 4'd5, S_OVOFF = 4'd6, S_LATCH = 4'd7,
                         S_INITOV = 4'd8;

  logic clk, rst_n;
  logic supply_ok, uvlo_ok, uvhi_ok, ovhi, ovlo, cb, cl, gate_low;
  logic gate_en, fault, cl_act;
  logic [2:0] tmode;
  logic [3:0] state;
  logic [W-1:0] timer;

  int n_chk = 0;
  int n_err = 0;

  hsw_seq_ctrl #(
    .TMR_W(W), .TMR_HI(HI), .TMR_LO(LO),
    .TMR_SLOW(SLOW), .TMR_FAST(FAST), .TMR_QUICK(QUICK)
  ) u_hsw_seq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .supply_ok_i(supply_ok), .win_uvlo_ok_i(uvlo_ok), .win_uvhi_ok_i(uvhi_ok),
    .win_ovhi_i(ovhi), .win_ovlo_i(ovlo), .sns_cb_i(cb), .sns_cl_i(cl),
    .gate_low_i(gate_low),
    .gate_en_o(gate_en), .tmr_mode_o(tmode), .state_o(state),
    .fault_latched_o(fault), .cl_active_o(cl_act), .timer_o(timer)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_st(input logic [3:0] s, input int maxc, input string req);
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (state == s) begin
        chk(1'b1, req, "reach state", state, s);
        return;
      end
    end
    chk(1'b0, req, "reach state", state, s);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; supply_ok = 0; uvlo_ok = 0; uvhi_ok = 0; ovhi = 0; ovlo = 0;
    cb = 0; cl = 0; gate_low = 0;
    repeat (3) @(negedge clk);
    chk(state == S_LOCK && !gate_en && timer == 0, "R1", "in reset", state, S_LOCK);
    rst_n = 1'b1;
    @(negedge clk);
    chk(state == S_LOCK, "R1", "state after reset", state, S_LOCK);
    chk(!gate_en && !fault && !cl_act, "R1", "outputs after reset", {gate_en, fault, cl_act}, 0);
    chk(timer == 0, "R1", "timer after reset", timer, 0);
  endtask

  task automatic t_start_gating();
    supply_ok = 1; uvlo_ok = 1; uvhi_ok = 1; gate_low = 0; cb = 0;
    repeat (20) @(negedge clk);
    chk(state == S_WAIT, "R4", "gate not low blocks init", state, S_WAIT);
    gate_low = 1; cb = 1;
    repeat (20) @(negedge clk);
    chk(state == S_WAIT, "R4", "breaker blocks init", state, S_WAIT);
    cb = 0;
    wait_st(S_INIT, 10, "R4");
  endtask

  task automatic t_init_cycle();
    int a;
    @(negedge clk);
    a = timer;
    @(negedge clk);
    chk(timer == a + SLOW, "R2", "initial climb step", timer - a, SLOW);
    wait_st(S_CLEAR, 150, "R2");
    chk(timer >= HI, "R2", "timer at end of initial cycle", timer, HI);
    gate_low = 0;
    @(negedge clk);
    chk(timer == ((timer + QUICK) - QUICK) && state == S_CLEAR, "R3", "still clearing", state, S_CLEAR);
    wait_st(S_ARM, 20, "R3");
    chk(timer <= LO, "R3", "timer at arm", timer, LO);
    repeat (10) @(negedge clk);
    chk(state == S_ARM && !gate_en, "R3", "arm waits for gate low", state, S_ARM);
    gate_low = 1;
    wait_st(S_RUN, 6, "R3");
    chk(gate_en == 1'b1, "R3", "gate enabled in run", gate_en, 1);
  endtask

  task automatic t_run_rates();
    int pk, a;
    repeat (10) @(negedge clk);
    chk(timer == 0, "R5", "timer decays to zero", timer, 0);
    cb = 1;
    @(negedge clk);
    @(negedge clk);
    cb = 0;
    pk = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (int'(timer) > pk) pk = timer;
    end
    chk(pk == 2 * FAST, "R5", "two fast steps", pk, 2 * FAST);
    chk(gate_en && state == S_RUN, "R6", "short fault does not trip", state, S_RUN);
    a = timer;
    @(negedge clk);
    chk(a - int'(timer) == SLOW, "R5", "slow decay step", a - int'(timer), SLOW);
    repeat (90) @(negedge clk);
    chk(timer == 0, "R5", "decay saturates at zero", timer, 0);
  endtask

  task automatic t_accumulate();
    for (int p = 0; p < 2; p++) begin
      cb = 1;
      @(negedge clk);
      cb = 0;
      repeat (9) @(negedge clk);
      chk(state == S_RUN && gate_en, "R6", "pulse below trip", state, S_RUN);
    end
    cb = 1;
    @(negedge clk);
    cb = 0;
    for (int i = 0; i < 10; i++) begin
      if (int'(timer) >= HI) break;
      @(negedge clk);
    end
    chk(int'(timer) == 408, "R6", "accumulated peak", timer, 408);
    chk(state == S_RUN, "R6", "run when trip level first seen", state, S_RUN);
    @(negedge clk);
    chk(state == S_LATCH, "R6", "latched next cycle", state, S_LATCH);
    chk(!gate_en && fault, "R6", "gate off and fault set", {gate_en, fault}, 1);
  endtask

  task automatic t_latch_hold();
    int a;
    cb = 1; ovhi = 1; ovlo = 1;
    repeat (30) @(negedge clk);
    cb = 0; ovhi = 0; ovlo = 0;
    repeat (30) @(negedge clk);
    chk(state == S_LATCH && !gate_en, "R7", "latch ignores breaker and overvoltage", state, S_LATCH);
    a = timer;
    @(negedge clk);
    chk(int'(timer) == a + SLOW, "R7", "latched timer climbs slowly", timer, a + SLOW);
    uvlo_ok = 0; uvhi_ok = 0;
    repeat (3) @(negedge clk);
    chk(state == S_LOCK && timer == 0 && !fault, "R8", "lockout clears latch", state, S_LOCK);
  endtask

  task automatic t_lockout();
    uvlo_ok = 1;
    repeat (20) @(negedge clk);
    chk(state == S_LOCK, "R8", "hysteresis holds lockout", state, S_LOCK);
    uvhi_ok = 1;
    wait_st(S_INIT, 10, "R8");
    wait_st(S_RUN, 200, "R8");
    uvlo_ok = 0;
    @(negedge clk);
    @(negedge clk);
    chk(state == S_RUN && gate_en, "R11", "no response before third edge", state, S_RUN);
    @(negedge clk);
    chk(state == S_LOCK && !gate_en, "R11", "response at third edge", state, S_LOCK);
    chk(timer == 0, "R8", "lockout clears timer", timer, 0);
    uvlo_ok = 1; uvhi_ok = 1;
  endtask

  task automatic t_ov_init();
    wait_st(S_INIT, 20, "R9");
    repeat (20) @(negedge clk);
    ovhi = 1; ovlo = 1;
    wait_st(S_INITOV, 5, "R9");
    chk(!gate_en, "R9", "gate off in power-up overvoltage", gate_en, 0);
    repeat (10) @(negedge clk);
    chk(timer == 0, "R9", "timer discharged", timer, 0);
    ovhi = 0;
    repeat (20) @(negedge clk);
    chk(state == S_INITOV, "R9", "waits for low trip", state, S_INITOV);
    ovlo = 0;
    wait_st(S_INIT, 10, "R9");
  endtask

  task automatic t_ov_run();
    int t;
    wait_st(S_RUN, 200, "R10");
    repeat (10) @(negedge clk);
    cb = 1;
    @(negedge clk);
    cb = 0; ovhi = 1; ovlo = 1;
    wait_st(S_OVOFF, 6, "R10");
    t = timer;
    chk(t > 0, "R10", "timer nonzero on entry", t, 1);
    repeat (30) @(negedge clk);
    chk(int'(timer) == t, "R10", "timer held", timer, t);
    chk(!gate_en, "R10", "gate off", gate_en, 0);
    ovhi = 0;
    repeat (10) @(negedge clk);
    chk(state == S_OVOFF, "R10", "held until low trip clears", state, S_OVOFF);
    ovlo = 0;
    wait_st(S_RUN, 6, "R10");
    chk(gate_en, "R10", "gate back on", gate_en, 1);
  endtask

  task automatic t_cl();
    chk(!cl_act, "R12", "no limit flag", cl_act, 0);
    cl = 1;
    repeat (3) @(negedge clk);
    chk(cl_act, "R12", "limit seen while running", cl_act, 1);
    supply_ok = 0;
    repeat (3) @(negedge clk);
    chk(state == S_LOCK && !cl_act, "R12", "limit masked outside run", cl_act, 0);
    cl = 0;
  endtask

  initial begin
    t_reset();
    t_start_gating();
    t_init_cycle();
    t_run_rates();
    t_accumulate();
    t_latch_hold();
    t_lockout();
    t_ov_init();
    t_ov_run();
    t_cl();
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule